// File: doc/BRIEF.md
# Vectored Interrupt Service Address Fetch

This block resolves the service routine address of a maskable interrupt taken in vectored mode on an 8-bit processor. When the interrupt is acknowledged, the peripheral supplies one byte on the acknowledge data lines. The block takes that byte as the low half of a 16-bit table pointer and a software-loaded base register as the high half. It then fetches the two bytes stored at that pointer, which give the entry address of the handler.

The first byte fetched, at the even pointer, is the low half of the handler address. The second byte, at the pointer plus one, is the high half. The assembled address is presented with a one-cycle strobe, and the program counter loads it as the target of an indirect call in place of its usual increment. A vector byte with its least significant bit set is invalid. Such a byte is flagged and rounded down to the even entry. Each of the two reads is a request that is held until a response-valid handshake arrives, so the memory may add any number of wait cycles.

Top module: `irq_vector_fetch`

## Requirements
- R1: After a synchronous reset, tgt_valid, mem_req, busy and vec_err are 0, tgt_addr is 0, and the base register holds 0.
- R2: A cycle with base_ld high writes base_din into the base register. Every later fetch uses that value as bits 15:8 of the table pointer.
- R3: The first read of a fetch addresses the table pointer. Bits 15:8 of the pointer are the base register. Bits 7:1 are bits 7:1 of the accepted vector byte, and bit 0 is 0.
- R4: From the cycle after an acknowledge is accepted, vec_err equals bit 0 of the accepted vector byte (1 means odd and invalid). It holds that value until the next accepted acknowledge. An odd vector is still served, from the even entry just below it.
- R5: The second read addresses the table pointer plus 1. The byte returned by the first read becomes tgt_addr[7:0], and the byte returned by the second read becomes tgt_addr[15:8].
- R6: mem_req stays high and mem_addr stays unchanged until a cycle with mem_rvalid high completes that read, whatever the number of wait cycles. mem_rvalid is sampled only while mem_req is high.
- R7: tgt_valid is high for exactly one cycle per fetch. tgt_addr keeps its value until the next fetch completes.
- R8: An acknowledge is accepted only while busy is 0. An acknowledge during any later step of a fetch, including the cycle with tgt_valid high, changes neither the result nor vec_err, and starts no new fetch.
- R9: The pointer takes the base register value held in the cycle after acceptance. A base load made after that cycle does not change the pointer of the fetch already in progress.
- R10: If ack is high in cycle c and each read is answered after W wait cycles, tgt_valid is high in cycle c+4+2W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_ld | input | 1 | Load strobe for the base register |
| base_din | input | 8 | New base register value |
| ack | input | 1 | Interrupt acknowledge, vector byte valid |
| ack_data | input | 8 | Vector byte from the peripheral |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | 16 | Memory read address |
| mem_rvalid | input | 1 | Read response valid |
| mem_rdata | input | 8 | Read response byte |
| tgt_valid | output | 1 | One-cycle strobe for the service address |
| tgt_addr | output | 16 | Service routine address |
| vec_err | output | 1 | Last accepted vector byte was odd |
| busy | output | 1 | A fetch is in progress |

## Verification
On every cycle the assertions check the read handshake: the address holds during wait cycles, the first request always starts on an even address that carries the base byte, and the second read follows at the next address. They also check that the result strobe lasts one cycle and comes only after the odd-address response, and that an acknowledge during a fetch leaves the error flag unchanged. The bench scenarios are what show the byte order of the assembled address, the handling of odd vectors, the exact latency under wait cycles, and that a base load made during a fetch does not reach that fetch. The bench sweeps every vector byte across several base values and wait counts.

// File: rtl/ivf_pkg.sv
package ivf_pkg;

  typedef enum logic [2:0] {
    ST_IDLE       = 3'd0,
    ST_ACK_VECTOR = 3'd1,
    ST_READ_LO    = 3'd2,
    ST_READ_HI    = 3'd3,
    ST_DONE       = 3'd4
  } ivf_state_t;

endpackage

// File: rtl/ivf_base_reg.sv
module ivf_base_reg #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ld,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q
);

  always_ff @(posedge clk) begin
    if (rst) begin
      q <= '0;
    end else if (ld) begin
      q <= din;
    end
  end

  // R2
  base_load_chk: assert property (@(posedge clk) disable iff (rst)
    ld |=> (q == $past(din)));

endmodule

// File: rtl/ivf_vec_capture.sv
module ivf_vec_capture #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              accept,
  input  logic [DATA_W-1:0] vec_in,
  input  logic [DATA_W-1:0] base_q,
  output logic [ADDR_W-1:0] ptr,
  output logic              err
);

  logic [DATA_W-1:1] vec_hi;
  logic [DATA_W-1:0] low_byte;

  always_ff @(posedge clk) begin
    if (rst) begin
      vec_hi <= '0;
      err    <= 1'b0;
    end else if (accept) begin
      vec_hi <= vec_in[DATA_W-1:1];
      err    <= vec_in[0];
    end
  end

  // table entries are two bytes wide: bit 0 of the pointer is always cleared
  genvar gi;
  generate
    for (gi = 0; gi < DATA_W; gi++) begin : g_low
      if (gi == 0) begin : g_even
        assign low_byte[gi] = 1'b0;
      end else begin : g_copy
        assign low_byte[gi] = vec_hi[gi];
      end
    end
  endgenerate

  assign ptr = {base_q, low_byte};

  // R4
  err_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !accept |=> $stable(err));

endmodule

// File: rtl/ivf_fetch_seq.sv
module ivf_fetch_seq
  import ivf_pkg::*;
#(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ack,
  input  logic [ADDR_W-1:0] ptr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              accept,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              tgt_valid,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              busy
);

  ivf_state_t        state;
  logic [DATA_W-1:0] lo_q;

  assign accept = (state == ST_IDLE) && ack;
  assign busy   = (state != ST_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      mem_req   <= 1'b0;
      mem_addr  <= '0;
      lo_q      <= '0;
      tgt_valid <= 1'b0;
      tgt_addr  <= '0;
    end else begin
      case (state)
        ST_IDLE: begin
          if (ack) state <= ST_ACK_VECTOR;
        end
        ST_ACK_VECTOR: begin
          mem_addr <= ptr;
          mem_req  <= 1'b1;
          state    <= ST_READ_LO;
        end
        ST_READ_LO: begin
          if (mem_rvalid) begin
            lo_q     <= mem_rdata;
            mem_addr <= {mem_addr[ADDR_W-1:1], 1'b1};
            state    <= ST_READ_HI;
          end
        end
        ST_READ_HI: begin
          if (mem_rvalid) begin
            tgt_addr  <= {mem_rdata, lo_q};
            tgt_valid <= 1'b1;
            mem_req   <= 1'b0;
            state     <= ST_DONE;
          end
        end
        ST_DONE: begin
          tgt_valid <= 1'b0;
          state     <= ST_IDLE;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  // R5
  second_read_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_rvalid && !mem_addr[0]) |=>
      (mem_req && mem_addr == $past(mem_addr) + 1'b1));

  // R7
  one_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    tgt_valid |=> !tgt_valid);

  // R5
  result_after_hi_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(tgt_valid) |-> $past(mem_req && mem_rvalid && mem_addr[0]));

endmodule

// File: rtl/irq_vector_fetch.sv
module irq_vector_fetch #(
  parameter int DATA_W = 8,
  localparam int ADDR_W = 2 * DATA_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_ld,
  input  logic [DATA_W-1:0] base_din,
  input  logic              ack,
  input  logic [DATA_W-1:0] ack_data,
  output logic              mem_req,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              tgt_valid,
  output logic [ADDR_W-1:0] tgt_addr,
  output logic              vec_err,
  output logic              busy
);

  logic [DATA_W-1:0] base_q;
  logic [ADDR_W-1:0] ptr;
  logic              accept;

  ivf_base_reg #(.DATA_W(DATA_W)) u_base (
    .clk (clk),
    .rst (rst),
    .ld  (base_ld),
    .din (base_din),
    .q   (base_q)
  );

  ivf_vec_capture #(.DATA_W(DATA_W)) u_vec (
    .clk    (clk),
    .rst    (rst),
    .accept (accept),
    .vec_in (ack_data),
    .base_q (base_q),
    .ptr    (ptr),
    .err    (vec_err)
  );

  ivf_fetch_seq #(.DATA_W(DATA_W)) u_seq (
    .clk        (clk),
    .rst        (rst),
    .ack        (ack),
    .ptr        (ptr),
    .mem_rvalid (mem_rvalid),
    .mem_rdata  (mem_rdata),
    .accept     (accept),
    .mem_req    (mem_req),
    .mem_addr   (mem_addr),
    .tgt_valid  (tgt_valid),
    .tgt_addr   (tgt_addr),
    .busy       (busy)
  );

  // R3
  first_read_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_req) |-> (!mem_addr[0] && mem_addr[ADDR_W-1:DATA_W] == $past(base_q)));

  // R8
  busy_ignore_chk: assert property (@(posedge clk) disable iff (rst)
    (ack && busy) |=> $stable(vec_err));

endmodule

// File: tb/irq_vector_fetch_test.sv
module irq_vector_fetch_test;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_ld = 1'b0;
  logic [7:0]  base_din = '0;
  logic        ack = 1'b0;
  logic [7:0]  ack_data = '0;
  logic        mem_req;
  logic [15:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [7:0]  mem_rdata = '0;
  logic        tgt_valid;
  logic [15:0] tgt_addr;
  logic        vec_err;
  logic        busy;

  int checks = 0;
  int fails  = 0;

  int          wait_cfg = 0;
  int          cnt = 0;
  int          rd_idx = 0;
  logic [15:0] cur_start = '0;
  logic [15:0] a0 = '0;
  logic [15:0] a1 = '0;
  bit          glitch = 1'b0;

  always #2 clk = ~clk;

  irq_vector_fetch uut (
    .clk(clk), .rst(rst), .base_ld(base_ld), .base_din(base_din),
    .ack(ack), .ack_data(ack_data), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .tgt_valid(tgt_valid),
    .tgt_addr(tgt_addr), .vec_err(vec_err), .busy(busy)
  );

  function automatic logic [7:0] mem_byte(input logic [15:0] a);
    logic [7:0] t;
    t = a[7:0] * 8'd7;
    t = t + a[15:8];
    return t ^ 8'h3C;
  endfunction

  // memory model: answers each request after wait_cfg idle cycles
  initial begin
    forever begin
      @(negedge clk);
      if (mem_req) begin
        if (cnt == 0) begin
          cur_start = mem_addr;
          if (rd_idx == 0) a0 = mem_addr; else a1 = mem_addr;
        end
        if (mem_addr != cur_start) glitch = 1'b1;
        if (cnt == wait_cfg) begin
          mem_rvalid = 1'b1;
          mem_rdata  = mem_byte(mem_addr);
          cnt = 0;
          rd_idx++;
        end else begin
          mem_rvalid = 1'b0;
          cnt++;
        end
      end else begin
        mem_rvalid = 1'b0;
        cnt = 0;
      end
    end
  end

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic load_base(input logic [7:0] b);
    @(negedge clk);
    base_ld = 1'b1; base_din = b;
    @(negedge clk);
    base_ld = 1'b0;
  endtask

  // mode 0 plain, 1 ack held busy with other vector, 2 base load mid-fetch
  task automatic fetch(input logic [7:0] base, input logic [7:0] vec,
                       input int w, input int mode);
    logic [15:0] p;
    logic [15:0] exp_t;
    logic [15:0] held;
    int n;
    p = {base, vec[7:1], 1'b0};
    exp_t = {mem_byte(p + 16'd1), mem_byte(p)};
    @(negedge clk);
    wait_cfg = w; rd_idx = 0; glitch = 1'b0;
    ack = 1'b1; ack_data = vec;
    @(negedge clk);
    n = 1;
    if (mode == 1) ack_data = ~vec; else ack = 1'b0;
    while (!tgt_valid && n < 200) begin
      if (mode == 2 && n == 2) begin base_ld = 1'b1; base_din = ~base; end
      else base_ld = 1'b0;
      @(negedge clk);
      n++;
    end
    base_ld = 1'b0;
    chk(tgt_valid, "R10", "timeout", 32'(n), 32'(4 + 2 * w));
    chk(n == 4 + 2 * w, "R10", "latency", 32'(n), 32'(4 + 2 * w));
    chk(a0 == p, "R3", "first read addr", a0, p);
    chk(a1 == p + 16'd1, "R5", "second read addr", a1, p + 16'd1);
    chk(!glitch, "R6", "addr held in wait", 32'(glitch), 0);
    chk(tgt_addr == exp_t, mode == 2 ? "R9" : "R5", "target", tgt_addr, exp_t);
    chk(vec_err == vec[0], mode == 1 ? "R8" : "R4", "vec_err", 32'(vec_err), 32'(vec[0]));
    held = tgt_addr;
    @(negedge clk);
    ack = 1'b0;
    chk(!tgt_valid, "R7", "strobe width", 32'(tgt_valid), 0);
    chk(tgt_addr == held, "R7", "target hold", tgt_addr, held);
    chk(!busy, "R8", "no fetch started", 32'(busy), 0);
    chk(!mem_req, "R8", "no request", 32'(mem_req), 0);
  endtask

  initial begin
    logic [7:0] bases [4];
    bases[0] = 8'h00; bases[1] = 8'h5A; bases[2] = 8'hA5; bases[3] = 8'hFF;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk(!tgt_valid && !mem_req && !busy && !vec_err, "R1", "flags",
        {tgt_valid, mem_req, busy, vec_err}, 0);
    chk(tgt_addr == 16'h0, "R1", "tgt_addr", tgt_addr, 0);
    fetch(8'h00, 8'h10, 0, 0);  // R1 base reset to 0, seen as pointer high byte

    // R2 R3 R4 R5 R10 sweep all vector bytes over several bases and waits
    for (int b = 0; b < 4; b++) begin
      load_base(bases[b]);
      for (int v = 0; v < 256; v++) begin
        fetch(bases[b], 8'(v), v % 3, 0);
      end
    end

    // R8 acknowledges while busy, through the strobe cycle
    load_base(8'h3C);
    fetch(8'h3C, 8'h22, 3, 1);
    fetch(8'h3C, 8'h81, 1, 1);
    fetch(8'h3C, 8'h00, 0, 1);

    // R9 base load during a fetch, then R2 the new base applies next time
    load_base(8'h71);
    fetch(8'h71, 8'h44, 3, 2);
    fetch(8'h8E, 8'h44, 0, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule